// File: doc/BRIEF.md
# Capture Time-Base Counter with Phase Preload

This block is a free-running up-counter that supplies the time-stamp sampled by a set of capture registers. While the count enable is high it advances by one on every clock. To line it up with other counters, it loads a programmable phase value when either a hardware sync input or a software-forced sync pulse is asserted.

For delta time-stamping, each of the capture load strobes has its own clear-enable bit. When a strobe arrives with its clear enabled, the count on the output during that cycle is the value to capture. The counter then reads zero from the next clock edge, so the following capture measures the time since this one. A sync wins over a clear in the same cycle.

The reset input is asserted asynchronously and active low. Its release is synchronised inside the block.

Top module: `capture_timebase`

## Requirements
- R1: While reset is asserted, and for the first cycles after its release, the count output is zero.
- R2: With the enable high and no sync or enabled clear, the count rises by exactly one per clock and wraps from all-ones to zero with no flag.
- R3: With the enable low and no sync or enabled clear, the count holds its value.
- R4: A high hardware sync input loads the phase value, and the count shows it after the next clock edge. It reads phase plus one one clock later if enabled.
- R5: A high software sync input loads the same phase value with the same timing as R4.
- R6: A load strobe whose clear-enable bit (same bit index) is set makes the count read zero after the next clock edge. During the strobe cycle the output still shows the pre-clear count. It reads one a clock later if enabled.
- R7: A load strobe whose clear-enable bit is clear has no effect on the count.
- R8: If a sync and an enabled clear occur in the same cycle, the phase load wins.
- R9: Sync loads and enabled clears both act while the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count enable; low holds the count |
| phase_val | input | 32 | Value loaded on a sync |
| hw_sync | input | 1 | Hardware sync request |
| sw_sync | input | 1 | Software-forced sync pulse |
| ld_stb | input | 4 | Capture load strobes, one bit per event |
| ld_clr_en | input | 4 | Per-event clear-after-capture enables, same bit order as ld_stb |
| count | output | 32 | Current time-stamp |

## Verification
Every action of the block shows at the output exactly one clock edge after the cycle in which its inputs are presented. An increment, a phase load or a clear all appear after one register. The count seen during a strobe cycle is still the old value. A reference model in the bench applies the same one-edge rule with the priority sync, then enabled clear, then increment, then hold. The bench drives inputs on the falling edge and compares the output on the next falling edge, so each check sees the result of exactly one rising edge. The reset-release delay is allowed for by waiting with the counter held before comparison begins.

// File: rtl/ts_pkg.sv
package ts_pkg;
  // what the counter does at the next edge, in priority order
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_LOAD = 2'd3
  } ts_act_e;
endpackage

// File: rtl/ts_rst_sync.sv
module ts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ts_clr_match.sv
module ts_clr_match #(
  parameter int NUM_EVT = 4
) (
  input  logic [NUM_EVT-1:0] ld_stb,
  input  logic [NUM_EVT-1:0] ld_clr_en,
  output logic               clr_hit
);
  logic [NUM_EVT-1:0] hit_vec;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign hit_vec[i] = ld_stb[i] & ld_clr_en[i];
  end

  assign clr_hit = |hit_vec;
endmodule

// File: rtl/ts_act_sel.sv
module ts_act_sel
  import ts_pkg::*;
(
  input  logic    sync_req,
  input  logic    clr_hit,
  input  logic    cnt_en,
  output ts_act_e act
);
  always_comb begin
    if (sync_req)     act = ACT_LOAD;
    else if (clr_hit) act = ACT_CLR;
    else if (cnt_en)  act = ACT_INC;
    else              act = ACT_HOLD;
  end
endmodule

// File: rtl/ts_cnt_core.sv
module ts_cnt_core
  import ts_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ts_act_e          act,
  input  logic             sync_req,
  input  logic             clr_hit,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] phase_val,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_we = (act != ACT_HOLD);
    unique case (act)
      ACT_LOAD: cnt_d = phase_val;
      ACT_CLR:  cnt_d = '0;
      ACT_INC:  cnt_d = cnt_q + 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  // R4
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> cnt_q == $past(phase_val));
  // R6
  evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !sync_req) |=> cnt_q == '0);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !sync_req && !clr_hit) |=> $stable(cnt_q));
  // R2
  inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !sync_req && !clr_hit) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/capture_timebase.sv
module capture_timebase
  import ts_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 4,
  parameter int RST_STG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  logic [CNT_W-1:0]   phase_val,
  input  logic               hw_sync,
  input  logic               sw_sync,
  input  logic [NUM_EVT-1:0] ld_stb,
  input  logic [NUM_EVT-1:0] ld_clr_en,
  output logic [CNT_W-1:0]   count
);
  logic    rst_sync_n;
  logic    sync_req;
  logic    clr_hit;
  ts_act_e act;

  assign sync_req = hw_sync | sw_sync;

  ts_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ts_clr_match #(.NUM_EVT(NUM_EVT)) u_clr (
    .ld_stb(ld_stb), .ld_clr_en(ld_clr_en), .clr_hit(clr_hit)
  );

  ts_act_sel u_sel (
    .sync_req(sync_req), .clr_hit(clr_hit), .cnt_en(cnt_en), .act(act)
  );

  ts_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .act(act), .sync_req(sync_req),
    .clr_hit(clr_hit), .cnt_en(cnt_en), .phase_val(phase_val), .cnt_q(count)
  );

  // R8
  sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sync_req && clr_hit) |=> count == $past(phase_val));
  // R1
  rst_zero_chk: assert property (@(posedge clk)
    !rst_sync_n |-> count == '0);
endmodule

// File: tb/capture_timebase_test.sv
module capture_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic [31:0] phase_val;
  logic        hw_sync, sw_sync;
  logic [3:0]  ld_stb, ld_clr_en;
  logic [31:0] count;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] expv;
  string tag;

  always #10 clk = ~clk;

  capture_timebase uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .phase_val(phase_val),
    .hw_sync(hw_sync), .sw_sync(sw_sync), .ld_stb(ld_stb),
    .ld_clr_en(ld_clr_en), .count(count)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    total = total + 1;
    if (act !== exp_v) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // one cycle: inputs presented now, model advances, result compared next falling edge
  task automatic step(input logic en, input logic hs, input logic ss,
                      input logic [3:0] ld, input logic [3:0] ce,
                      input logic [31:0] ph, input string req);
    cnt_en = en; hw_sync = hs; sw_sync = ss; ld_stb = ld; ld_clr_en = ce; phase_val = ph;
    tag = req;
    if (hs || ss)         expv = ph;
    else if (|(ld & ce))  expv = 32'd0;
    else if (en)          expv = expv + 32'd1;
    @(negedge clk);
    check(req, count, expv);
  endtask

  initial begin
    rst_n = 1'b0; cnt_en = 1'b1; phase_val = 32'h0; hw_sync = 1'b0; sw_sync = 1'b0;
    ld_stb = 4'h0; ld_clr_en = 4'h0;
    expv = 32'd0;
    repeat (3) @(negedge clk);
    check("R1", count, 32'd0);
    cnt_en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", count, 32'd0);

    // R2 counting
    for (int i = 0; i < 5; i++) step(1, 0, 0, 4'h0, 4'h0, 32'h0, "R2");
    // R3 hold
    for (int i = 0; i < 3; i++) step(0, 0, 0, 4'h0, 4'h0, 32'h0, "R3");
    // R4 hardware sync then phase+1
    step(1, 1, 0, 4'h0, 4'h0, 32'h0000_1234, "R4");
    step(1, 0, 0, 4'h0, 4'h0, 32'h0, "R4");
    // R5 software sync
    step(1, 0, 1, 4'h0, 4'h0, 32'h00AB_0000, "R5");
    step(1, 0, 0, 4'h0, 4'h0, 32'h0, "R5");
    // R2 wrap via phase near all-ones
    step(1, 1, 0, 4'h0, 4'h0, 32'hFFFF_FFFE, "R2");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 4'h0, 4'h0, 32'h0, "R2");
    // R6 each event with its own clear enable; pre-clear value visible during strobe
    for (int e = 0; e < 4; e++) begin
      for (int i = 0; i < 3; i++) step(1, 0, 0, 4'h0, 4'h0, 32'h0, "R6");
      check("R6", count, expv);
      step(1, 0, 0, 4'(1 << e), 4'(1 << e), 32'h0, "R6");
      step(1, 0, 0, 4'h0, 4'h0, 32'h0, "R6");
    end
    // R7 strobe without its enable (enable set on other bits)
    for (int e = 0; e < 4; e++)
      step(1, 0, 0, 4'(1 << e), ~4'(1 << e), 32'h0, "R7");
    // R8 sync beats clear
    step(1, 1, 0, 4'hF, 4'hF, 32'h5555_0000, "R8");
    step(1, 0, 1, 4'h2, 4'h2, 32'h0000_0777, "R8");
    // R9 while held
    step(0, 1, 0, 4'h0, 4'h0, 32'h0000_9000, "R9");
    step(0, 0, 0, 4'h0, 4'h0, 32'h0, "R9");
    step(0, 0, 0, 4'h8, 4'h8, 32'h0, "R9");
    step(0, 0, 0, 4'h0, 4'h0, 32'h0, "R9");
    step(0, 0, 1, 4'h0, 4'h0, 32'h0000_0042, "R9");
    // mixed run
    for (int i = 0; i < 40; i++)
      step(i % 3 != 0, i % 11 == 5, i % 13 == 7, 4'(i), 4'(i * 5), 32'(i * 1000), "R2");
    // R1 reset again mid-run
    rst_n = 1'b0;
    #1;
    check("R1", count, 32'd0);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule